// File: doc/BRIEF.md
# Endian-Selectable Byte Lane Steering

This block sits between a byte-serial stream and a four-lane 32-bit bus. Each request carries a byte offset within the Dword, a size code (one byte, two bytes or a full Dword) and the stream bytes packed low-first: the first byte of the stream is in bits [7:0]. The block places those bytes onto the bus lanes and raises byte enables for exactly the lanes it fills. A mode input chooses little endian ordering, where stream bytes climb from the lane equal to the offset, or big endian ordering, where each byte lands on the lane mirrored across the Dword.

Full Dword requests are never reordered, in either mode. For slave accesses to internal registers, whose lanes never move, the block also outputs a remapped offset that the register decoder uses in place of the raw one. The mode input is followed while no transfer is open and frozen while one is, so a mode change made mid-transfer applies from the next transfer. The lane logic is combinational, and a parameter adds an optional output register stage.

Top module: `byte_lane_steer`

## Requirements
- R1: Little endian (mode 0), size code 0 (byte) or 1 (half): stream byte i is placed on lane offset+i, and bus bits [8*L+7:8*L] form lane L.
- R2: Big endian (mode 1), size code 0 or 1: stream byte i is placed on lane (offset+i) XOR 3, so offset 0 maps to lane 3 and offset 3 maps to lane 0.
- R3: Size code 2 (Dword) at offset 0 passes the 32-bit data to the lanes unchanged and enables all four lanes, in both modes.
- R4: The byte enables are set for exactly the lanes that received a stream byte. Every other lane carries zero data.
- R5: A request is misaligned if it has size code 3, a half at an odd offset, or a Dword at a nonzero offset. A misaligned request raises the misalign output, drives all enables low and drives all data to zero.
- R6: The register offset output equals the request offset in little endian mode and for Dwords. In big endian mode it is offset XOR 3 for bytes and offset XOR 2 for halves. On a misaligned request it is the raw offset.
- R7: The effective mode follows the mode input while the transfer-open input is low, and keeps its last value while transfer-open is high.
- R8: With the default output register, each result appears one clock after its request. Reset clears the output valid, enables, misalign flag and data.
- R9: A cycle with the request valid low produces output valid low and all enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_mode_i | input | 1 | 1 = big endian, 0 = little endian |
| xfer_open_i | input | 1 | High while a transfer is in progress (freezes the mode) |
| req_valid_i | input | 1 | Request present this cycle |
| req_off_i | input | 2 | Byte offset within the Dword |
| req_size_i | input | 2 | 0 byte, 1 half, 2 Dword, 3 invalid |
| req_data_i | input | 32 | Stream bytes packed low-first |
| out_valid_o | output | 1 | Result valid |
| lane_data_o | output | 32 | Lane-aligned data |
| lane_be_o | output | 4 | Per-lane byte enables |
| reg_off_o | output | 2 | Remapped offset for register decode |
| misalign_o | output | 1 | Request misaligned or size invalid |

## Verification
The assertions on the enable counts take the size code as the whole description of the access. They assume nothing about the stream data bytes above the access width; the stimulus deliberately fills those bytes with nonzero values, so that a leak onto an unused lane would show. The mode-hold property assumes transfer-open is a level that stays high for the length of a transfer. The stimulus changes it only at falling clock edges, together with the mode input, so that both the frozen and the live mode paths are exercised.

// File: rtl/bls_pkg.sv
package bls_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } xfer_size_e;
endpackage

// File: rtl/bls_mode_hold.sv
module bls_mode_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_i,
   input  logic hold_i,
   output logic mode_o
);
   logic mode_q;
   logic past_ok;

   assign mode_o = hold_i ? mode_q : mode_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 1'b0;
         past_ok <= 1'b0;
      end else begin
         mode_q  <= mode_o;
         past_ok <= 1'b1;
      end
   end

   // R7
   mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && hold_i && $past(hold_i)) |-> $stable(mode_o));
endmodule

// File: rtl/bls_lane_map.sv
module bls_lane_map
   import bls_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   localparam int OFF_W = $clog2(LANES),
   localparam int DW    = LANES * BYTE_W
) (
   input  logic             big_i,
   input  logic [1:0]       size_i,
   input  logic [OFF_W-1:0] off_i,
   input  logic [DW-1:0]    data_i,
   output logic [DW-1:0]    data_o,
   output logic [LANES-1:0] be_o,
   output logic [OFF_W-1:0] roff_o,
   output logic             err_o
);
   xfer_size_e       sz;
   int               nb;
   logic [OFF_W-1:0] amask;
   logic [OFF_W-1:0] lane_x;
   logic [OFF_W-1:0] reg_x;
   logic [OFF_W-1:0] lane;

   always_comb begin
      sz = xfer_size_e'(size_i);
      case (sz)
         SZ_BYTE: nb = 1;
         SZ_HALF: nb = 2;
         SZ_WORD: nb = LANES;
         default: nb = 0;
      endcase
      amask  = (nb > 0) ? OFF_W'(nb - 1) : '0;
      err_o  = (sz == SZ_BAD) || ((off_i & amask) != '0);
      lane_x = (big_i && sz != SZ_WORD) ? OFF_W'(LANES - 1) : '0;
      case (sz)
         SZ_BYTE: reg_x = big_i ? OFF_W'(LANES - 1) : '0;
         SZ_HALF: reg_x = big_i ? OFF_W'(LANES - 2) : '0;
         default: reg_x = '0;
      endcase
      roff_o = err_o ? off_i : (off_i ^ reg_x);
      data_o = '0;
      be_o   = '0;
      lane   = '0;
      if (!err_o) begin
         for (int i = 0; i < LANES; i++) begin
            if (i < nb) begin
               lane = (off_i + OFF_W'(i)) ^ lane_x;
               data_o[int'(lane)*BYTE_W +: BYTE_W] = data_i[i*BYTE_W +: BYTE_W];
               be_o[lane] = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/bls_out_stage.sv
module bls_out_stage #(
   parameter int  W       = 8,
   parameter bit  OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vld_i,
   input  logic [W-1:0] pay_i,
   output logic         vld_o,
   output logic [W-1:0] pay_o
);
   generate
      if (OUT_REG) begin : g_reg
         logic         vld_q;
         logic [W-1:0] pay_q;
         logic         past_ok;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q   <= 1'b0;
               pay_q   <= '0;
               past_ok <= 1'b0;
            end else begin
               vld_q   <= vld_i;
               pay_q   <= pay_i;
               past_ok <= 1'b1;
            end
         end
         assign vld_o = vld_q;
         assign pay_o = pay_q;

         // R8
         one_cycle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> (vld_o == $past(vld_i)) && (pay_o == $past(pay_i)));
      end else begin : g_wire
         assign vld_o = vld_i;
         assign pay_o = pay_i;
      end
   endgenerate
endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer
   import bls_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int BYTE_W  = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int OFF_W  = $clog2(LANES),
   localparam int DW     = LANES * BYTE_W,
   localparam int PAY_W  = 1 + OFF_W + LANES + DW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             big_mode_i,
   input  logic             xfer_open_i,
   input  logic             req_valid_i,
   input  logic [OFF_W-1:0] req_off_i,
   input  logic [1:0]       req_size_i,
   input  logic [DW-1:0]    req_data_i,
   output logic             out_valid_o,
   output logic [DW-1:0]    lane_data_o,
   output logic [LANES-1:0] lane_be_o,
   output logic [OFF_W-1:0] reg_off_o,
   output logic             misalign_o
);
   generate
      if (LANES != 4) begin : g_bad_lanes
         $error("byte_lane_steer: LANES must be 4");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("byte_lane_steer: BYTE_W must be positive");
      end
   endgenerate

   logic             mode_eff;
   logic [DW-1:0]    map_data;
   logic [LANES-1:0] map_be;
   logic [OFF_W-1:0] map_roff;
   logic             map_err;
   logic [PAY_W-1:0] pay_in;
   logic [PAY_W-1:0] pay_out;

   bls_mode_hold u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (big_mode_i),
      .hold_i (xfer_open_i),
      .mode_o (mode_eff)
   );

   bls_lane_map #(.LANES(LANES), .BYTE_W(BYTE_W)) u_map (
      .big_i  (mode_eff),
      .size_i (req_size_i),
      .off_i  (req_off_i),
      .data_i (req_data_i),
      .data_o (map_data),
      .be_o   (map_be),
      .roff_o (map_roff),
      .err_o  (map_err)
   );

   assign pay_in = req_valid_i ? {map_err, map_roff, map_be, map_data} : '0;

   bls_out_stage #(.W(PAY_W), .OUT_REG(OUT_REG)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (req_valid_i),
      .pay_i (pay_in),
      .vld_o (out_valid_o),
      .pay_o (pay_out)
   );

   assign {misalign_o, reg_off_o, lane_be_o, lane_data_o} = pay_out;

   // R3
   word_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_size_i == SZ_WORD && req_off_i == '0) |->
         (map_data == req_data_i) && (&map_be) && (map_roff == '0));
   // R4
   byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_size_i == SZ_BYTE) |-> $onehot0(map_be) && $countones(map_be) == 1);
   // R4
   half_two_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_size_i == SZ_HALF && !req_off_i[0]) |-> $countones(map_be) == 2);
   // R5
   misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      map_err |-> (map_be == '0) && (map_data == '0));
   // R9
   idle_no_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid_o |-> (lane_be_o == '0));
endmodule

// File: tb/byte_lane_steer_tb.sv
`timescale 1ns/1ps
module byte_lane_steer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        big_mode_i = 1'b0;
   logic        xfer_open_i = 1'b0;
   logic        req_valid_i = 1'b0;
   logic [1:0]  req_off_i = '0;
   logic [1:0]  req_size_i = '0;
   logic [31:0] req_data_i = '0;
   logic        out_valid_o;
   logic [31:0] lane_data_o;
   logic [3:0]  lane_be_o;
   logic [1:0]  reg_off_o;
   logic        misalign_o;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   byte_lane_steer u_dut (
      .clk(clk), .rst_n(rst_n), .big_mode_i(big_mode_i), .xfer_open_i(xfer_open_i),
      .req_valid_i(req_valid_i), .req_off_i(req_off_i), .req_size_i(req_size_i),
      .req_data_i(req_data_i), .out_valid_o(out_valid_o), .lane_data_o(lane_data_o),
      .lane_be_o(lane_be_o), .reg_off_o(reg_off_o), .misalign_o(misalign_o)
   );

   localparam logic [31:0] D = 32'hDDCCBBAA;
   // {big, size, off, exp_be, exp_data, exp_err, exp_roff}
   localparam int NV = 15;
   localparam logic [43:0] VEC [NV] = '{
      {1'b0, 2'd0, 2'd0, 4'b0001, 32'h000000AA, 1'b0, 2'd0},  // R1
      {1'b0, 2'd0, 2'd2, 4'b0100, 32'h00AA0000, 1'b0, 2'd2},  // R1
      {1'b0, 2'd1, 2'd2, 4'b1100, 32'hBBAA0000, 1'b0, 2'd2},  // R1
      {1'b0, 2'd1, 2'd0, 4'b0011, 32'h0000BBAA, 1'b0, 2'd0},  // R1
      {1'b1, 2'd0, 2'd0, 4'b1000, 32'hAA000000, 1'b0, 2'd3},  // R2 R6
      {1'b1, 2'd0, 2'd3, 4'b0001, 32'h000000AA, 1'b0, 2'd0},  // R2 R6
      {1'b1, 2'd0, 2'd1, 4'b0100, 32'h00AA0000, 1'b0, 2'd2},  // R2
      {1'b1, 2'd1, 2'd0, 4'b1100, 32'hAABB0000, 1'b0, 2'd2},  // R2 R6
      {1'b1, 2'd1, 2'd2, 4'b0011, 32'h0000AABB, 1'b0, 2'd0},  // R2 R6
      {1'b0, 2'd2, 2'd0, 4'b1111, 32'hDDCCBBAA, 1'b0, 2'd0},  // R3
      {1'b1, 2'd2, 2'd0, 4'b1111, 32'hDDCCBBAA, 1'b0, 2'd0},  // R3 R6
      {1'b0, 2'd1, 2'd1, 4'b0000, 32'h00000000, 1'b1, 2'd1},  // R5
      {1'b1, 2'd2, 2'd2, 4'b0000, 32'h00000000, 1'b1, 2'd2},  // R5
      {1'b0, 2'd3, 2'd0, 4'b0000, 32'h00000000, 1'b1, 2'd0},  // R5
      {1'b1, 2'd1, 2'd3, 4'b0000, 32'h00000000, 1'b1, 2'd3}   // R5
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(logic big, logic open, logic vld, logic [1:0] sz,
                        logic [1:0] off, logic [31:0] dat);
      @(negedge clk);
      big_mode_i = big; xfer_open_i = open; req_valid_i = vld;
      req_size_i = sz; req_off_i = off; req_data_i = dat;
   endtask

   task automatic settle();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #100000;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R8 reset state
      settle();
      check("R8 reset valid", 32'(out_valid_o), 32'd0);
      check("R8 reset be", 32'(lane_be_o), 32'd0);
      check("R8 reset err", 32'(misalign_o), 32'd0);
      check("R8 reset data", lane_data_o, 32'd0);
      @(negedge clk); rst_n = 1'b1;

      // table walk (R1 R2 R3 R4 R5 R6)
      for (int k = 0; k < NV; k++) begin
         logic [43:0] v;
         v = VEC[k];
         drive(v[43], 1'b0, 1'b1, v[42:41], v[40:39], D);
         settle();
         check("R4 vec be", 32'(lane_be_o), 32'(v[38:35]));
         check("R1/R2/R3 vec data", lane_data_o, v[34:3]);
         check("R5 vec err", 32'(misalign_o), 32'(v[2]));
         check("R6 vec roff", 32'(reg_off_o), 32'(v[1:0]));
      end

      // R9 idle cycle
      drive(1'b0, 1'b0, 1'b0, 2'd0, 2'd1, D);
      settle();
      check("R9 idle valid", 32'(out_valid_o), 32'd0);
      check("R9 idle be", 32'(lane_be_o), 32'd0);

      // R8 latency: before the edge the old (idle) output remains
      drive(1'b0, 1'b0, 1'b1, 2'd0, 2'd1, D);
      #1;
      check("R8 pre-edge be", 32'(lane_be_o), 32'd0);
      settle();
      check("R8 post-edge be", 32'(lane_be_o), 32'b0010);
      check("R8 post-edge valid", 32'(out_valid_o), 32'd1);

      // R7 mode held while transfer open
      drive(1'b0, 1'b0, 1'b0, 2'd0, 2'd0, D);
      settle();
      drive(1'b1, 1'b1, 1'b1, 2'd0, 2'd0, D);
      settle();
      check("R7 frozen little", 32'(lane_be_o), 32'b0001);
      drive(1'b1, 1'b1, 1'b1, 2'd1, 2'd0, D);
      settle();
      check("R7 still frozen", lane_data_o, 32'h0000BBAA);
      drive(1'b1, 1'b0, 1'b1, 2'd0, 2'd0, D);
      settle();
      check("R7 live big", 32'(lane_be_o), 32'b1000);
      drive(1'b0, 1'b1, 1'b1, 2'd0, 2'd0, D);
      settle();
      check("R7 frozen big", 32'(lane_be_o), 32'b1000);

      // R4 unused lanes stay zero with busy upper stream bytes
      drive(1'b0, 1'b0, 1'b1, 2'd0, 2'd3, 32'hFFFFFF5A);
      settle();
      check("R4 unused zero", lane_data_o, 32'h5A000000);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule